// File: doc/BRIEF.md
# Cross-Pair Counter Cascade Controller

This block holds four wide event counters split into two pairs, pair A (counters 0 and 1) and pair B (counters 2 and 3). Each counter is either started directly by its own enable bit, or started automatically by a chain link. With a chain link, the counter runs once a partner counter in the other pair has overflowed. The link bit is set in the control of the counter that is to be started. Each counter has its own sticky overflow flag. The flag is set when the counter wraps from all ones to zero.

There are two link types. The normal link pairs counter 0 with counter 2 and counter 1 with counter 3, and it works in either direction. The alternate link is present only on counters chosen by a parameter. It pairs counter i with counter 3-i. When both link bits are set, only the alternate link applies. A link-started counter stops when its link bit is cleared, or when software clears the partner's overflow flag. A single interrupt request output is raised while any counter has both its overflow flag and its interrupt-enable bit set.

Software drives the block through plain pins: a control write port, a counter preset port and a per-counter overflow-clear vector. Event inputs are per-cycle increment strobes, one per counter. The block has no streamed data, so it has no valid/ready handshake. Every write takes effect at the clock edge on which it is presented, and every strobe is always accepted.

Top module: `xpair_cascade_ctrl`

## Requirements
- R1: After reset, all counters read 0, all overflow flags and run indications are 0, and the interrupt request is 0.
- R2: A counter whose enable bit is set adds 1 on each clock edge at which its event strobe is high. A counter with no enable and no active link ignores its strobe.
- R3: A counting step from all ones gives 0 and sets the counter's overflow flag. The flag stays set until its bit in the overflow-clear vector is pulsed.
- R4: A counter with only the normal link bit set (enable clear) stays idle until its normal partner (index XOR 2) has its overflow flag set, and then counts its own strobes.
- R5: A strobe on the link-started counter in the same cycle as the partner's wrap is not counted. Counting begins on the following cycle.
- R6: A link-started counter stops counting when its link bit is cleared, or when its partner's overflow flag is cleared.
- R7: On a counter allowed by the EXT_CAP parameter (default counters 0 and 2), the alternate link bit starts the counter from the overflow of counter 3-index.
- R8: On a counter not allowed by EXT_CAP, the alternate link bit has no effect.
- R9: When both link bits are set on a capable counter, only the alternate partner is used. The overflow of the normal partner does not start it.
- R10: irq_o is high while, for some counter, both the overflow flag and the interrupt-enable bit are set. Overflow with the interrupt enable clear does not raise irq_o.
- R11: A preset write on a counter takes priority over that counter's increment on the same edge.
- R12: When an overflow and a clear pulse for the same counter arrive on the same edge, the overflow wins and the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_idx | input | 2 | Counter addressed by the control write |
| cfg_en | input | 1 | Direct enable bit to write |
| cfg_casc | input | 1 | Normal link bit to write |
| cfg_ext | input | 1 | Alternate link bit to write |
| cfg_irq | input | 1 | Interrupt-enable bit to write |
| ld_we | input | 1 | Counter preset strobe |
| ld_idx | input | 2 | Counter addressed by the preset |
| ld_val | input | CNT_W | Preset value |
| ovf_clr | input | 4 | Per-counter overflow flag clear pulses |
| evt | input | 4 | Per-counter event strobes |
| cnt_o | output | 4*CNT_W | Counter values, counter i at bits [i*CNT_W +: CNT_W] |
| ovf_o | output | 4 | Sticky overflow flags |
| run_o | output | 4 | Counters currently allowed to count |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps every counter through direct counting, wrap and overflow. It also sweeps every normal link in both directions and every alternate link. The wrap cycle is the most important corner. A design that looks at the partner's next-state overflow would count the strobe that arrives in that same cycle, and the count would come out one high. The bench also checks both ways of stopping a chain. A design that latched the started state would keep counting after the link or the partner flag is cleared. Finally, it checks that a design which honoured both link bits, or honoured the alternate bit on a counter without the capability, would start from the wrong partner. It checks the priority of preset over increment, and of set over clear.

// File: rtl/xpc_pkg.sv
package xpc_pkg;
  // Four counters: pair A = {0,1}, pair B = {2,3}
  localparam int unsigned NCNT  = 4;
  localparam int unsigned IDX_W = $clog2(NCNT);

  // Normal link: the same slot in the other pair
  function automatic int unsigned base_mate(int unsigned i);
    return i ^ 2;
  endfunction

  // Alternate link: the opposite slot in the other pair
  function automatic int unsigned alt_mate(int unsigned i);
    return (NCNT - 1) - i;
  endfunction
endpackage

// File: rtl/xpc_ctl_bank.sv
module xpc_ctl_bank
  import xpc_pkg::*;
#(
  parameter logic [NCNT-1:0] EXT_CAP = 4'b0101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_en,
  input  logic             cfg_casc,
  input  logic             cfg_ext,
  input  logic             cfg_irq,
  output logic [NCNT-1:0]  en_q,
  output logic [NCNT-1:0]  casc_q,
  output logic [NCNT-1:0]  ext_q,
  output logic [NCNT-1:0]  irq_q
);
  for (genvar g = 0; g < NCNT; g++) begin : g_slot
    logic hit;
    assign hit = cfg_we && (cfg_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[g]   <= 1'b0;
        casc_q[g] <= 1'b0;
        ext_q[g]  <= 1'b0;
        irq_q[g]  <= 1'b0;
      end else if (hit) begin
        en_q[g]   <= cfg_en;
        casc_q[g] <= cfg_casc;
        ext_q[g]  <= cfg_ext & EXT_CAP[g];
        irq_q[g]  <= cfg_irq;
      end
    end

    if (!EXT_CAP[g]) begin : g_noext
      AST_EXT_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_q[g]); // R8
    end
  end
endmodule

// File: rtl/xpc_link.sv
module xpc_link
  import xpc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCNT-1:0] en_q,
  input  logic [NCNT-1:0] casc_q,
  input  logic [NCNT-1:0] ext_q,
  input  logic [NCNT-1:0] ovf_q,
  output logic [NCNT-1:0] run
);
  for (genvar g = 0; g < NCNT; g++) begin : g_lnk
    localparam int unsigned BM = base_mate(g);
    localparam int unsigned AM = alt_mate(g);
    logic mate_ovf;
    logic link_on;

    // The alternate link overrides the normal link when both are set
    assign mate_ovf = ext_q[g] ? ovf_q[AM] : ovf_q[BM];
    assign link_on  = ext_q[g] | casc_q[g];
    assign run[g]   = en_q[g] | (link_on & mate_ovf);

    AST_EXT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_q[g] && !en_q[g] && !ovf_q[AM]) |-> !run[g]); // R9
    AST_CASC_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[g] && !ext_q[g] && !ovf_q[BM]) |-> !run[g]); // R4
  end
endmodule

// File: rtl/xpc_counter.sv
module xpc_counter #(
  parameter int unsigned CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             inc,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  logic step;
  logic wrap;
  assign step = run && inc && !ld;
  assign wrap = step && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (ld)        cnt <= ld_val;
      else if (step) cnt <= cnt + 1'b1;
      if (wrap)      ovf <= 1'b1;
      else if (clr)  ovf <= 1'b0;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> $stable(cnt)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && inc && !ld && cnt != {CNT_W{1'b1}}) |=> cnt == $past(cnt) + 1'b1); // R2
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (run && inc && !ld && cnt == {CNT_W{1'b1}}) |=> (cnt == '0) && ovf); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf); // R3
  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(ld_val)); // R11
endmodule

// File: rtl/xpair_cascade_ctrl.sv
module xpair_cascade_ctrl
  import xpc_pkg::*;
#(
  parameter int unsigned      CNT_W   = 40,
  parameter logic [NCNT-1:0]  EXT_CAP = 4'b0101
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [IDX_W-1:0]      cfg_idx,
  input  logic                  cfg_en,
  input  logic                  cfg_casc,
  input  logic                  cfg_ext,
  input  logic                  cfg_irq,
  input  logic                  ld_we,
  input  logic [IDX_W-1:0]      ld_idx,
  input  logic [CNT_W-1:0]      ld_val,
  input  logic [NCNT-1:0]       ovf_clr,
  input  logic [NCNT-1:0]       evt,
  output logic [NCNT*CNT_W-1:0] cnt_o,
  output logic [NCNT-1:0]       ovf_o,
  output logic [NCNT-1:0]       run_o,
  output logic                  irq_o
);
  logic [NCNT-1:0] en_q, casc_q, ext_q, irq_q;

  xpc_ctl_bank #(.EXT_CAP(EXT_CAP)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_en(cfg_en), .cfg_casc(cfg_casc), .cfg_ext(cfg_ext), .cfg_irq(cfg_irq),
    .en_q(en_q), .casc_q(casc_q), .ext_q(ext_q), .irq_q(irq_q)
  );

  xpc_link u_link (
    .clk(clk), .rst_n(rst_n),
    .en_q(en_q), .casc_q(casc_q), .ext_q(ext_q), .ovf_q(ovf_o),
    .run(run_o)
  );

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    xpc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .run(run_o[g]), .inc(evt[g]),
      .ld(ld_we && (ld_idx == IDX_W'(g))), .ld_val(ld_val),
      .clr(ovf_clr[g]),
      .cnt(cnt_o[g*CNT_W +: CNT_W]), .ovf(ovf_o[g])
    );

    AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o[g] && irq_q[g]) |-> irq_o); // R10
  end

  assign irq_o = |(ovf_o & irq_q);

  AST_IRQ_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($countones(ovf_o) > 0)); // R10
endmodule

// File: tb/xpair_cascade_ctrl_tb.sv
module xpair_cascade_ctrl_tb;
  localparam int W = 40;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_en = 0, cfg_casc = 0, cfg_ext = 0, cfg_irq = 0;
  logic [1:0] cfg_idx = 0, ld_idx = 0;
  logic ld_we = 0;
  logic [W-1:0] ld_val = 0;
  logic [3:0] ovf_clr = 0, evt = 0;
  logic [4*W-1:0] cnt_o;
  logic [3:0] ovf_o, run_o;
  logic irq_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  xpair_cascade_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_en(cfg_en), .cfg_casc(cfg_casc), .cfg_ext(cfg_ext), .cfg_irq(cfg_irq),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_val(ld_val), .ovf_clr(ovf_clr),
    .evt(evt), .cnt_o(cnt_o), .ovf_o(ovf_o), .run_o(run_o), .irq_o(irq_o)
  );

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] cv(int i);
    return cnt_o[i*W +: W];
  endfunction

  task automatic do_reset();
    rst_n = 0; evt = 0; ovf_clr = 0; cfg_we = 0; ld_we = 0;
    tick(2);
    rst_n = 1;
  endtask

  task automatic cfg(int idx, bit en, bit casc, bit ext, bit irq);
    cfg_we = 1; cfg_idx = 2'(idx);
    cfg_en = en; cfg_casc = casc; cfg_ext = ext; cfg_irq = irq;
    tick();
    cfg_we = 0;
  endtask

  task automatic load(int idx, logic [W-1:0] v);
    ld_we = 1; ld_idx = 2'(idx); ld_val = v;
    tick();
    ld_we = 0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick();
    do_reset();
    // R1 reset state
    chk("R1 cnt", 64'(cnt_o == '0), 64'd1);
    chk("R1 ovf", 64'(ovf_o), 64'd0);
    chk("R1 run", 64'(run_o), 64'd0);
    chk("R1 irq", 64'(irq_o), 64'd0);

    // R2 direct counting; other counters ignore strobes
    for (int i = 0; i < 4; i++) begin
      do_reset();
      cfg(i, 1, 0, 0, 0);
      evt = 4'hF;
      tick(i + 3);
      evt = 0;
      for (int j = 0; j < 4; j++)
        chk("R2 count", 64'(cv(j)), (j == i) ? 64'(i + 3) : 64'd0);
    end

    // R3 wrap and sticky flag, then clear
    for (int i = 0; i < 4; i++) begin
      do_reset();
      cfg(i, 1, 0, 0, 0);
      load(i, MAXV - 1);
      evt = 4'(1 << i);
      tick();
      chk("R3 pre-wrap cnt", 64'(cv(i)), 64'(MAXV));
      chk("R3 pre-wrap ovf", 64'(ovf_o[i]), 64'd0);
      tick();
      evt = 0;
      chk("R3 wrap cnt", 64'(cv(i)), 64'd0);
      chk("R3 wrap ovf", 64'(ovf_o[i]), 64'd1);
      tick(3);
      chk("R3 sticky", 64'(ovf_o[i]), 64'd1);
      ovf_clr = 4'(1 << i);
      tick();
      ovf_clr = 0;
      chk("R3 cleared", 64'(ovf_o[i]), 64'd0);
    end

    // R4/R5/R6 normal link in every direction
    for (int i = 0; i < 4; i++) begin
      automatic int p = i ^ 2;
      do_reset();
      cfg(p, 1, 0, 0, 0);
      cfg(i, 0, 1, 0, 0);
      load(p, MAXV);
      chk("R4 idle before partner ovf", 64'(run_o[i]), 64'd0);
      evt = 4'((1 << i) | (1 << p));
      tick();
      chk("R5 wrap-cycle strobe not counted", 64'(cv(i)), 64'd0);
      chk("R4 started", 64'(run_o[i]), 64'd1);
      tick(3);
      evt = 0;
      chk("R4 linked count", 64'(cv(i)), 64'd3);
      cfg(i, 0, 0, 0, 0);
      evt = 4'(1 << i);
      tick(2);
      evt = 0;
      chk("R6 stop on link clear", 64'(cv(i)), 64'd3);
      cfg(i, 0, 1, 0, 0);
      chk("R6 relinked", 64'(run_o[i]), 64'd1);
      ovf_clr = 4'(1 << p);
      tick();
      ovf_clr = 0;
      evt = 4'(1 << i);
      tick(2);
      evt = 0;
      chk("R6 stop on partner clear", 64'(cv(i)), 64'd3);
      chk("R6 run off", 64'(run_o[i]), 64'd0);
    end

    // R7 alternate link on capable counters; R9 both bits -> alternate only
    for (int k = 0; k < 2; k++) begin
      automatic int i = 2 * k;
      automatic int a = 3 - i;
      automatic int p = i ^ 2;
      do_reset();
      cfg(a, 1, 0, 0, 0);
      cfg(i, 0, 0, 1, 0);
      load(a, MAXV);
      evt = 4'((1 << i) | (1 << a));
      tick(3);
      evt = 0;
      chk("R7 alternate start", 64'(cv(i)), 64'd2);
      do_reset();
      cfg(p, 1, 0, 0, 0);
      cfg(i, 0, 1, 1, 0);
      load(p, MAXV);
      evt = 4'((1 << i) | (1 << p));
      tick(3);
      evt = 0;
      chk("R9 normal partner ignored", 64'(cv(i)), 64'd0);
      chk("R9 partner did overflow", 64'(ovf_o[p]), 64'd1);
      cfg(a, 1, 0, 0, 0);
      load(a, MAXV);
      evt = 4'((1 << i) | (1 << a));
      tick(3);
      evt = 0;
      chk("R9 alternate partner used", 64'(cv(i)), 64'd2);
    end

    // R8 alternate bit on counters without the capability
    for (int k = 0; k < 2; k++) begin
      automatic int i = 2 * k + 1;
      automatic int a = 3 - i;
      do_reset();
      cfg(a, 1, 0, 0, 0);
      cfg(i, 0, 0, 1, 0);
      load(a, MAXV);
      evt = 4'((1 << i) | (1 << a));
      tick(3);
      evt = 0;
      chk("R8 ext ignored cnt", 64'(cv(i)), 64'd0);
      chk("R8 ext ignored run", 64'(run_o[i]), 64'd0);
    end

    // R10 interrupt request
    do_reset();
    cfg(1, 1, 0, 0, 0);
    load(1, MAXV);
    evt = 4'b0010;
    tick();
    evt = 0;
    chk("R10 no irq without enable", 64'(irq_o), 64'd0);
    cfg(3, 1, 0, 0, 1);
    load(3, MAXV);
    evt = 4'b1000;
    tick();
    evt = 0;
    chk("R10 irq raised", 64'(irq_o), 64'd1);
    ovf_clr = 4'b1000;
    tick();
    ovf_clr = 0;
    chk("R10 irq dropped", 64'(irq_o), 64'd0);

    // R11 preset beats increment
    do_reset();
    cfg(0, 1, 0, 0, 0);
    evt = 4'b0001;
    load(0, 40'd100);
    chk("R11 preset wins", 64'(cv(0)), 64'd100);
    tick();
    evt = 0;
    chk("R11 counts after preset", 64'(cv(0)), 64'd101);

    // R12 set beats clear
    do_reset();
    cfg(2, 1, 0, 0, 0);
    load(2, MAXV);
    evt = 4'b0100;
    ovf_clr = 4'b0100;
    tick();
    evt = 0;
    ovf_clr = 0;
    chk("R12 set wins", 64'(ovf_o[2]), 64'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule